// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital half of a dual-slope integrating converter. The integrator, comparator and voltage reference sit outside it in the analog front end. A start request sets off one conversion in three phases. First, an auto-zero output discharges the integrator for a short fixed window. Next, the input switch is closed so the unknown voltage is integrated for a fixed run-up time counted in clocks. Last, the integrator is moved onto the negative reference, and the block counts clocks until the comparator reports that the integrator has come back down through zero.

The run-down count is the result. Because the run-up time is fixed, the count is proportional to the input: the input equals the reference times the run-down count divided by the run-up count. When the run-down runs out of time before the comparator trips, the block finishes with an overrange flag and a saturated result. A one-cycle done pulse marks each finished conversion. The result and the flag then hold until the next conversion completes.

Top module: `dsadc_seq`

## Requirements
- R1: After synchronous reset, `busy_o`, `az_o`, `sel_in_o`, `sel_ref_o`, `done_o` and `ovr_o` are 0 and `result_o` is 0.
- R2: A `start_i` high sampled at a clock edge while idle raises `busy_o` and `az_o` at that edge. `az_o` then stays high for exactly AZ_CYC (4) cycles.
- R3: `sel_in_o` rises at the edge where `az_o` falls and stays high for exactly RUNUP_CYC (4096) cycles. At most one of `az_o`, `sel_in_o` and `sel_ref_o` is high in any cycle.
- R4: `sel_ref_o` rises at the edge where `sel_in_o` falls. It stays high until the edge at which `cmp_i` is sampled low, where `cmp_i` high means the integrator is still above zero. The result is the number of run-down edges at which `cmp_i` was sampled high.
- R5: If `cmp_i` is still sampled high at the RUNDN_MAX-th (4096th) run-down edge, the conversion ends at that edge with `ovr_o` = 1 and `result_o` all ones (4095).
- R6: `done_o` is high for exactly one cycle, at the edge where `busy_o` falls. `result_o` and `ovr_o` change only at that edge and are stable at all other times.
- R7: `start_i` is ignored while `busy_o` is high. It neither restarts nor lengthens the conversion, and it does not trigger a second conversion afterwards.
- R8: A comparator trip at the last allowed run-down edge gives `result_o` = 4095 with `ovr_o` = 0. A trip at the first run-down edge gives `result_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Conversion request, sampled while idle |
| cmp_i | input | 1 | Comparator output, high while the integrator is above zero |
| busy_o | output | 1 | Conversion in progress |
| az_o | output | 1 | Auto-zero switch: discharge the integrator |
| sel_in_o | output | 1 | Input switch: integrate the unknown voltage |
| sel_ref_o | output | 1 | Reference switch: integrate the negative reference |
| result_o | output | RES_W (12) | Run-down count of the last conversion |
| ovr_o | output | 1 | Last conversion ran out of run-down time |
| done_o | output | 1 | One-cycle pulse when a conversion finishes |

## Verification
Every output changes at the clock edge that samples its cause. `busy_o` and `az_o` rise at the edge that takes the start. Each switch output hands over to the next at the edge that ends the previous phase. `done_o`, `result_o` and `ovr_o` update at the very edge where `cmp_i` is first sampled low, or at the 4096th run-down edge. The bench drives inputs and samples outputs on the falling edge, so each value is read half a cycle after the edge that produced it. Its ramp model updates `cmp_i` on the falling edge from the integrator value before that cycle's step, so the expected count is the ceiling of 4096·vin/vref, computed in a bench function.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_AZERO = 2'd1,
    ST_RUNUP = 2'd2,
    ST_RUNDN = 2'd3
  } dsadc_state_t;

  function automatic int imax3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/dsadc_phase_ctr.sv
module dsadc_phase_ctr #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  output logic [CNT_W-1:0] cnt
);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (en) begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/dsadc_ctrl.sv
module dsadc_ctrl
  import dsadc_pkg::*;
#(
  parameter int AZ_CYC    = 4,
  parameter int RUNUP_CYC = 4096,
  parameter int RUNDN_MAX = 4096,
  parameter int CNT_W     = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             cmp,
  input  logic [CNT_W-1:0] cnt,
  output logic             ctr_clr,
  output logic             ctr_en,
  output logic             finish,
  output logic             ovr_evt,
  output logic             busy,
  output logic             az,
  output logic             sel_in,
  output logic             sel_ref
);

  localparam logic [CNT_W-1:0] AZ_LAST = CNT_W'(AZ_CYC - 1);
  localparam logic [CNT_W-1:0] RU_LAST = CNT_W'(RUNUP_CYC - 1);
  localparam logic [CNT_W-1:0] RD_LAST = CNT_W'(RUNDN_MAX - 1);

  dsadc_state_t state, nxt;

  always_comb begin
    nxt     = state;
    ctr_clr = 1'b0;
    ctr_en  = 1'b0;
    finish  = 1'b0;
    ovr_evt = 1'b0;
    unique case (state)
      ST_IDLE: begin
        ctr_clr = 1'b1;
        if (start) nxt = ST_AZERO;
      end
      ST_AZERO: begin
        if (cnt == AZ_LAST) begin
          nxt     = ST_RUNUP;
          ctr_clr = 1'b1;
        end else begin
          ctr_en = 1'b1;
        end
      end
      ST_RUNUP: begin
        if (cnt == RU_LAST) begin
          nxt     = ST_RUNDN;
          ctr_clr = 1'b1;
        end else begin
          ctr_en = 1'b1;
        end
      end
      ST_RUNDN: begin
        // cmp low: integrator has crossed zero, count stands as result
        if (!cmp) begin
          nxt    = ST_IDLE;
          finish = 1'b1;
        end else if (cnt == RD_LAST) begin
          nxt     = ST_IDLE;
          finish  = 1'b1;
          ovr_evt = 1'b1;
        end else begin
          ctr_en = 1'b1;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  // switch controls come from the next state so they change with the state flop
  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      busy    <= 1'b0;
      az      <= 1'b0;
      sel_in  <= 1'b0;
      sel_ref <= 1'b0;
    end else begin
      state   <= nxt;
      busy    <= (nxt != ST_IDLE);
      az      <= (nxt == ST_AZERO);
      sel_in  <= (nxt == ST_RUNUP);
      sel_ref <= (nxt == ST_RUNDN);
    end
  end

endmodule

// File: rtl/dsadc_result.sv
module dsadc_result #(
  parameter int CNT_W = 12,
  parameter int RES_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             finish,
  input  logic             ovr_evt,
  input  logic [CNT_W-1:0] cnt,
  output logic [RES_W-1:0] result,
  output logic             ovr,
  output logic             done
);

  logic [RES_W-1:0] cnt_sat;

  generate
    if (CNT_W > RES_W) begin : g_sat
      assign cnt_sat = (cnt > CNT_W'({RES_W{1'b1}})) ? '1 : cnt[RES_W-1:0];
    end else begin : g_ext
      assign cnt_sat = RES_W'(cnt);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      ovr    <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= finish;
      if (finish) begin
        result <= ovr_evt ? '1 : cnt_sat;
        ovr    <= ovr_evt;
      end
    end
  end

endmodule

// File: rtl/dsadc_seq.sv
module dsadc_seq
  import dsadc_pkg::*;
#(
  parameter int RES_W     = 12,
  parameter int AZ_CYC    = 4,
  parameter int RUNUP_CYC = 4096,
  parameter int RUNDN_MAX = 4096
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             cmp_i,
  output logic             busy_o,
  output logic             az_o,
  output logic             sel_in_o,
  output logic             sel_ref_o,
  output logic [RES_W-1:0] result_o,
  output logic             ovr_o,
  output logic             done_o
);

  localparam int MAX_PHASE = imax3(AZ_CYC, RUNUP_CYC, RUNDN_MAX);
  localparam int CNT_W     = (MAX_PHASE > 1) ? $clog2(MAX_PHASE) : 1;

  logic [CNT_W-1:0] cnt;
  logic             ctr_clr, ctr_en, finish, ovr_evt;

  dsadc_phase_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk (clk),
    .rst (rst),
    .clr (ctr_clr),
    .en  (ctr_en),
    .cnt (cnt)
  );

  dsadc_ctrl #(
    .AZ_CYC   (AZ_CYC),
    .RUNUP_CYC(RUNUP_CYC),
    .RUNDN_MAX(RUNDN_MAX),
    .CNT_W    (CNT_W)
  ) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .start  (start_i),
    .cmp    (cmp_i),
    .cnt    (cnt),
    .ctr_clr(ctr_clr),
    .ctr_en (ctr_en),
    .finish (finish),
    .ovr_evt(ovr_evt),
    .busy   (busy_o),
    .az     (az_o),
    .sel_in (sel_in_o),
    .sel_ref(sel_ref_o)
  );

  dsadc_result #(.CNT_W(CNT_W), .RES_W(RES_W)) u_res (
    .clk    (clk),
    .rst    (rst),
    .finish (finish),
    .ovr_evt(ovr_evt),
    .cnt    (cnt),
    .result (result_o),
    .ovr    (ovr_o),
    .done   (done_o)
  );

endmodule

// File: rtl/dsadc_seq_chk.sv
module dsadc_seq_chk #(
  parameter int RES_W  = 12,
  parameter int AZ_CYC = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic             busy_o,
  input logic             az_o,
  input logic             sel_in_o,
  input logic             sel_ref_o,
  input logic [RES_W-1:0] result_o,
  input logic             ovr_o,
  input logic             done_o
);

  localparam int AZR_W = $clog2(AZ_CYC + 1) + 1;

  logic [AZR_W-1:0] az_run;

  always_ff @(posedge clk) begin
    if (rst) az_run <= '0;
    else if (az_o) az_run <= az_run + 1'b1;
    else az_run <= '0;
  end

  // R2
  start_take_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && start_i) |=> (busy_o && az_o));

  // R2
  az_short_chk: assert property (@(posedge clk) disable iff (rst)
    az_o |-> (az_run < AZR_W'(AZ_CYC)));

  // R2
  az_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(az_o) |-> (az_run == AZR_W'(AZ_CYC)));

  // R3
  switch_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({az_o, sel_in_o, sel_ref_o}));

  // R3
  runup_follow_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(az_o) |-> sel_in_o);

  // R4
  rundown_follow_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(sel_in_o) |-> sel_ref_o);

  // R5
  ovr_ones_chk: assert property (@(posedge clk) disable iff (rst)
    ovr_o |-> (&result_o));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!busy_o && $fell(busy_o)));

  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> ($stable(result_o) && $stable(ovr_o)));

endmodule

bind dsadc_seq dsadc_seq_chk #(.RES_W(RES_W), .AZ_CYC(AZ_CYC)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start_i  (start_i),
  .busy_o   (busy_o),
  .az_o     (az_o),
  .sel_in_o (sel_in_o),
  .sel_ref_o(sel_ref_o),
  .result_o (result_o),
  .ovr_o    (ovr_o),
  .done_o   (done_o)
);

// File: tb/test_dsadc_seq.sv
`timescale 1ns/1ps
module test_dsadc_seq;

  localparam int RES_W = 12;
  localparam int AZ    = 4;
  localparam int RU    = 4096;
  localparam int RD    = 4096;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start_i = 1'b0;
  logic             cmp_i = 1'b0;
  logic             busy_o, az_o, sel_in_o, sel_ref_o, ovr_o, done_o;
  logic [RES_W-1:0] result_o;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  dsadc_seq #(.RES_W(RES_W), .AZ_CYC(AZ), .RUNUP_CYC(RU), .RUNDN_MAX(RD)) i_dsadc_seq (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .cmp_i    (cmp_i),
    .busy_o   (busy_o),
    .az_o     (az_o),
    .sel_in_o (sel_in_o),
    .sel_ref_o(sel_ref_o),
    .result_o (result_o),
    .ovr_o    (ovr_o),
    .done_o   (done_o)
  );

  // behavioural integrator ramp feeding the comparator
  longint integ = 0;
  int     vin   = 0;
  int     vref  = 4096;

  always @(negedge clk) begin
    cmp_i = (integ > 0);
    if (az_o) integ = 0;
    else if (sel_in_o) integ = integ + vin;
    else if (sel_ref_o) integ = integ - vref;
  end

  // phase monitor
  int               az_n = 0, in_n = 0, rd_n = 0;
  bit               clash = 0, res_moved = 0, track = 0;
  logic [RES_W-1:0] res_ref = '0;

  always @(negedge clk) begin
    if (az_o) az_n++;
    if (sel_in_o) in_n++;
    if (sel_ref_o) rd_n++;
    if ($countones({az_o, sel_in_o, sel_ref_o}) > 1) clash = 1;
    if (track && !done_o && result_o !== res_ref) res_moved = 1;
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint runs_needed(input int vi, input int vr);
    return (longint'(RU) * vi + vr - 1) / vr;
  endfunction

  task automatic run_conv(input int vi, input int vr, input bit poke);
    longint n;
    int     exp_res, exp_rd, k;
    bit     exp_ovr;
    n = runs_needed(vi, vr);
    if (n >= RD) begin
      exp_ovr = 1; exp_res = (1 << RES_W) - 1; exp_rd = RD;
    end else begin
      exp_ovr = 0; exp_res = int'(n); exp_rd = int'(n) + 1;
    end
    vin = vi; vref = vr;
    az_n = 0; in_n = 0; rd_n = 0; clash = 0; res_moved = 0;
    res_ref = result_o; track = 1;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o === 1'b1 && az_o === 1'b1, "R2 busy/az after start",
          {busy_o, az_o}, 3);
    k = 0;
    while (done_o !== 1'b1) begin
      @(negedge clk);
      k++;
      start_i = (poke && (k == 100 || k == 5000)) ? 1'b1 : 1'b0;
    end
    start_i = 1'b0;
    track = 0;
    check(result_o == RES_W'(exp_res), exp_ovr ? "R5 overrange result" :
          (exp_res == 0 || exp_res == 4095) ? "R8 edge result" : "R4 result",
          result_o, exp_res);
    check(ovr_o == exp_ovr, "R5 overrange flag", ovr_o, exp_ovr);
    check(az_n == AZ, "R2 auto-zero length", az_n, AZ);
    check(in_n == RU, "R3 run-up length", in_n, RU);
    check(rd_n == exp_rd, "R4 run-down length", rd_n, exp_rd);
    check(!clash, "R3 switch exclusive", clash, 0);
    check(!res_moved, "R6 result held during conversion", res_moved, 0);
    check(busy_o == 1'b0, "R6 busy low at done", busy_o, 0);
    @(negedge clk);
    check(done_o == 1'b0, "R6 done single cycle", done_o, 0);
    check(result_o == RES_W'(exp_res), "R6 result holds after done", result_o, exp_res);
    if (poke) begin
      repeat (3) @(negedge clk);
      check(busy_o == 1'b0 && az_n == AZ, "R7 start while busy ignored",
            {busy_o, az_n[3:0]}, AZ);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(busy_o == 0 && az_o == 0 && sel_in_o == 0 && sel_ref_o == 0 &&
          done_o == 0 && ovr_o == 0, "R1 control outputs in reset",
          {busy_o, az_o, sel_in_o, sel_ref_o, done_o, ovr_o}, 0);
    check(result_o == '0, "R1 result in reset", result_o, 0);
    rst = 1'b0;
    @(negedge clk);
    check(busy_o == 0 && az_o == 0, "R1 idle after reset", {busy_o, az_o}, 0);

    run_conv(0, 4096, 0);        // R8 trip at first run-down edge
    run_conv(1, 4096, 0);
    run_conv(4095, 4096, 0);     // R8 trip at last edge, no overrange
    run_conv(4096, 4096, 0);     // R5 full scale overruns
    run_conv(1500, 1000, 0);     // R5 above full scale
    run_conv(700, 1400, 1);      // R7 start pulses while busy
    for (int i = 0; i < 6; i++) begin
      int vr, vi;
      vr = int'($urandom_range(500, 4096));
      vi = int'($urandom_range(0, vr + vr / 16));
      run_conv(vi, vr, i[0]);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R6 watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule